// File: doc/BRIEF.md
# UART Request-to-Send Control and Multidrop Frame Builder

This block is the control slice of a UART channel that sits between the software-visible registers and the bit shifter. It keeps one request-to-send flag and drives it out as an active-low pin. Several sources can move that flag. Software can move it through dedicated port set and port reset strobes, or through two command codes. When enabled, the receive FIFO moves it as the FIFO fills and drains. When enabled, the transmitter drops it once the final character has fully left the line.

The block also holds one transmit character waiting for the shifter. When the shifter can take a character, the block hands it over as a 9-bit frame word with a one-clock load strobe. The top bit of that word is the multidrop address/data flag, sampled at the moment of the handover. Software may therefore change the flag as soon as the holding stage reports ready, without disturbing the character already on its way out.

Top module: `uart_rts_mdrop`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `rts_n` is 1, `tx_rdy` is 1 and `frame_load` is 0.
- R2: In the cycle after a clock edge at which `op_set_wr` is high with `op_rts_bit` 1, or `cmd_wr` is high with `cmd_code` equal to 4'h8, `rts_n` is 0. A port write with `op_rts_bit` 0 has no effect. Any command code other than 4'h8 or 4'h9 has no effect.
- R3: In the cycle after a clock edge at which `op_clr_wr` is high with `op_rts_bit` 1, or `cmd_wr` is high with `cmd_code` equal to 4'h9, `rts_n` is 1.
- R4: If a clear event and a set event occur at the same clock edge, `rts_n` is 1 in the following cycle.
- R5: When `rx_rts_en` is 1, a 0-to-1 change of `rx_fifo_full` clears the flag (`rts_n` becomes 1). A 1-to-0 change sets the flag (`rts_n` becomes 0) with no earlier manual assert. When `rx_rts_en` is 0, changes of `rx_fifo_full` have no effect.
- R6: When `tx_rts_en` is 1 and the holding stage is empty, a `tx_last_done` pulse clears the flag in the next cycle. The pulse is ignored while a character is still held, and it is ignored when `tx_rts_en` is 0.
- R7: `tx_rdy` is 1 exactly when the holding stage is empty. A `tx_buf_wr` while it is empty stores `tx_buf_data`, and `tx_rdy` is 0 in the next cycle. A write while it is full is discarded.
- R8: When the stage is full and `shift_ready` is 1 at a clock edge, the following cycle has `frame_load` 1, `tx_rdy` 1, and `frame_word` = {A/D flag, data}, with the A/D flag in bit 8 and the data in bits 7:0. `frame_load` lasts exactly one cycle, and `frame_word` is 0 whenever `frame_load` is 0.
- R9: Bit 8 of the frame equals `ad_bit` as sampled at the handover edge. Later changes of `ad_bit` affect only the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_set_wr | input | 1 | Write strobe of the output-port set register |
| op_clr_wr | input | 1 | Write strobe of the output-port reset register |
| op_rts_bit | input | 1 | Value written to the request-to-send bit position |
| cmd_wr | input | 1 | Command register write strobe |
| cmd_code | input | CMD_W | Command code |
| rx_rts_en | input | 1 | Receiver-controlled mode enable |
| tx_rts_en | input | 1 | Transmitter-controlled mode enable |
| rx_fifo_full | input | 1 | Receive FIFO full flag |
| tx_buf_wr | input | 1 | Transmit holding stage write strobe |
| tx_buf_data | input | DATA_W | Character to transmit |
| ad_bit | input | 1 | Multidrop address/data flag from the mode register |
| shift_ready | input | 1 | Shifter can accept a character |
| tx_last_done | input | 1 | Final stop bit has left the line |
| rts_n | output | 1 | Active-low request-to-send |
| tx_rdy | output | 1 | Holding stage empty |
| frame_load | output | 1 | One-cycle load strobe to the shifter |
| frame_word | output | DATA_W+1 | {A/D flag, data} for the shifter |

## Verification
The bench drives a set and a clear in the same cycle. A design that lets the set win would leave the pin low. It drives the FIFO full flag up and down with the receiver mode both on and off, starting from the cleared state. A design that only reacts after a manual assert, or that ignores the enable, would show the wrong pin level. It pulses end-of-transmission while a character is still held, to catch a design that drops the request too early. It changes the A/D flag right after the handover, and writes into a full holding stage. A design that samples the flag late, or overwrites the held byte, would put the wrong frame word out.

// File: rtl/uart_rts_mdrop.sv
module uart_rts_mdrop #(
  parameter int DATA_W = 8,
  parameter int CMD_W = 4,
  parameter logic [CMD_W-1:0] CMD_RTS_ON = 'h8,
  parameter logic [CMD_W-1:0] CMD_RTS_OFF = 'h9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_set_wr,
  input  logic              op_clr_wr,
  input  logic              op_rts_bit,
  input  logic              cmd_wr,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              rx_rts_en,
  input  logic              tx_rts_en,
  input  logic              rx_fifo_full,
  input  logic              tx_buf_wr,
  input  logic [DATA_W-1:0] tx_buf_data,
  input  logic              ad_bit,
  input  logic              shift_ready,
  input  logic              tx_last_done,
  output logic              rts_n,
  output logic              tx_rdy,
  output logic              frame_load,
  output logic [DATA_W:0]   frame_word
);
  logic              rts_on;
  logic              full_q;
  logic              buf_full;
  logic [DATA_W-1:0] buf_q;
  logic              load_q;
  logic [DATA_W:0]   word_q;

  wire sw_set  = (op_set_wr && op_rts_bit) || (cmd_wr && cmd_code == CMD_RTS_ON);
  wire sw_clr  = (op_clr_wr && op_rts_bit) || (cmd_wr && cmd_code == CMD_RTS_OFF);
  wire rx_fall = rx_rts_en && full_q && !rx_fifo_full;
  wire rx_rise = rx_rts_en && !full_q && rx_fifo_full;
  wire tx_end  = tx_rts_en && tx_last_done && !buf_full;
  wire xfer    = buf_full && shift_ready;
  wire accept  = !buf_full && tx_buf_wr;

  always_ff @(posedge clk) begin
    full_q <= rx_fifo_full;
    if (!rst_n)
      rts_on <= 1'b0;
    else if (sw_clr || rx_rise || tx_end)
      rts_on <= 1'b0;
    else if (sw_set || rx_fall)
      rts_on <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_full <= 1'b0;
      buf_q    <= '0;
      load_q   <= 1'b0;
      word_q   <= '0;
    end else begin
      load_q <= xfer;
      word_q <= xfer ? {ad_bit, buf_q} : '0;
      if (xfer)
        buf_full <= 1'b0;
      else if (accept) begin
        buf_full <= 1'b1;
        buf_q    <= tx_buf_data;
      end
    end
  end

  assign rts_n      = !rts_on;
  assign tx_rdy     = !buf_full;
  assign frame_load = load_q;
  assign frame_word = word_q;
endmodule

// File: rtl/uart_rts_mdrop_chk.sv
module uart_rts_mdrop_chk #(
  parameter int DATA_W = 8,
  parameter int CMD_W = 4,
  parameter logic [CMD_W-1:0] CMD_RTS_ON = 'h8,
  parameter logic [CMD_W-1:0] CMD_RTS_OFF = 'h9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_set_wr,
  input logic              op_clr_wr,
  input logic              op_rts_bit,
  input logic              cmd_wr,
  input logic [CMD_W-1:0]  cmd_code,
  input logic              rx_rts_en,
  input logic              tx_rts_en,
  input logic              rx_fifo_full,
  input logic              tx_buf_wr,
  input logic              ad_bit,
  input logic              shift_ready,
  input logic              tx_last_done,
  input logic              rts_n,
  input logic              tx_rdy,
  input logic              frame_load,
  input logic [DATA_W:0]   frame_word
);
  wire set_ev = (op_set_wr && op_rts_bit) || (cmd_wr && cmd_code == CMD_RTS_ON);
  wire clr_ev = (op_clr_wr && op_rts_bit) || (cmd_wr && cmd_code == CMD_RTS_OFF);

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n) $past(!rst_n) |-> (rts_n && tx_rdy && !frame_load)); // R1
  AST_SW_SET: assert property (@(posedge clk) disable iff (!rst_n) (set_ev && !clr_ev && !tx_last_done && !(rx_rts_en && $rose(rx_fifo_full))) |=> !rts_n); // R2
  AST_SW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_ev |=> rts_n); // R3
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n) (clr_ev && set_ev) |=> rts_n); // R4
  AST_RX_FULL_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (rx_rts_en && $rose(rx_fifo_full)) |=> rts_n); // R5
  AST_RX_DRAIN_SETS: assert property (@(posedge clk) disable iff (!rst_n) (rx_rts_en && $fell(rx_fifo_full) && !clr_ev && !tx_last_done) |=> !rts_n); // R5
  AST_TX_END_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (tx_rts_en && tx_last_done && tx_rdy) |=> rts_n); // R6
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n) (!tx_rdy && !shift_ready) |=> !tx_rdy); // R7
  AST_WRITE_FILLS: assert property (@(posedge clk) disable iff (!rst_n) (tx_rdy && tx_buf_wr) |=> !tx_rdy); // R7
  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) frame_load |=> !frame_load); // R8
  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) frame_load |-> tx_rdy); // R8
  AST_IDLE_WORD: assert property (@(posedge clk) disable iff (!rst_n) !frame_load |-> frame_word == '0); // R8
  AST_AD_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n) frame_load |-> frame_word[DATA_W] == $past(ad_bit)); // R9
  AST_NO_SPURIOUS_LOAD: assert property (@(posedge clk) disable iff (!rst_n) ($past(tx_rdy) || !$past(shift_ready)) |-> !frame_load); // R8
endmodule

bind uart_rts_mdrop uart_rts_mdrop_chk #(
  .DATA_W(DATA_W), .CMD_W(CMD_W), .CMD_RTS_ON(CMD_RTS_ON), .CMD_RTS_OFF(CMD_RTS_OFF)
) u_chk (.*);

// File: tb/sim_uart_rts_mdrop.sv
`timescale 1ns/1ps
module sim_uart_rts_mdrop;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic op_set_wr = 0, op_clr_wr = 0, op_rts_bit = 0, cmd_wr = 0;
  logic [3:0] cmd_code = 0;
  logic rx_rts_en = 0, tx_rts_en = 0, rx_fifo_full = 0, tx_buf_wr = 0;
  logic [7:0] tx_buf_data = 0;
  logic ad_bit = 0, shift_ready = 0, tx_last_done = 0;
  logic rts_n, tx_rdy, frame_load;
  logic [8:0] frame_word;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  uart_rts_mdrop u0 (.*);

  bit m_rts = 0, m_load = 0, m_pf = 0;
  logic [8:0] m_word = 0;
  logic [7:0] bq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_rts = 0; m_load = 0; m_word = 0; m_pf = rx_fifo_full; bq.delete();
    end else begin
      bit s, c;
      s = (op_set_wr && op_rts_bit) || (cmd_wr && cmd_code == 4'h8) || (rx_rts_en && m_pf && !rx_fifo_full);
      c = (op_clr_wr && op_rts_bit) || (cmd_wr && cmd_code == 4'h9) || (rx_rts_en && !m_pf && rx_fifo_full)
          || (tx_rts_en && tx_last_done && bq.size() == 0);
      if (c) m_rts = 0; else if (s) m_rts = 1;
      m_load = 0; m_word = 0;
      if (bq.size() != 0 && shift_ready) begin
        m_load = 1; m_word = {ad_bit, bq.pop_front()};
      end else if (bq.size() == 0 && tx_buf_wr) bq.push_back(tx_buf_data);
      m_pf = rx_fifo_full;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(rts_n == !m_rts, "model rts R2 R3 R4 R5 R6", rts_n, !m_rts);
    chk(tx_rdy == (bq.size() == 0), "model tx_rdy R7", tx_rdy, bq.size() == 0);
    chk(frame_load == m_load, "model load R8", frame_load, m_load);
    chk(frame_word == m_word, "model word R8 R9", frame_word, m_word);
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic summary();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog expired R1 actual=hung expected=finish");
    summary();
  end

  initial begin
    repeat (3) tick();
    chk(rts_n === 1 && tx_rdy === 1 && frame_load === 0, "R1 in reset", {rts_n, tx_rdy, frame_load}, 3'b110);
    rst_n = 1; tick();
    chk(rts_n === 1 && tx_rdy === 1 && frame_load === 0, "R1 after reset", {rts_n, tx_rdy, frame_load}, 3'b110);
    // R2 port set
    op_set_wr = 1; op_rts_bit = 1; tick(); op_set_wr = 0;
    chk(rts_n == 0, "R2 port set", rts_n, 0);
    // R3 clear with bit 0 ignored, then real clear
    op_clr_wr = 1; op_rts_bit = 0; tick(); op_clr_wr = 0;
    chk(rts_n == 0, "R3 clear bit zero ignored", rts_n, 0);
    op_clr_wr = 1; op_rts_bit = 1; tick(); op_clr_wr = 0;
    chk(rts_n == 1, "R3 port clear", rts_n, 1);
    // commands
    cmd_wr = 1; cmd_code = 4'h8; tick();
    chk(rts_n == 0, "R2 assert command", rts_n, 0);
    cmd_code = 4'h5; tick();
    chk(rts_n == 0, "R2 other code ignored", rts_n, 0);
    cmd_code = 4'h9; tick(); cmd_wr = 0;
    chk(rts_n == 1, "R3 negate command", rts_n, 1);
    // R4 clear wins
    cmd_wr = 1; cmd_code = 4'h8; tick(); cmd_wr = 0;
    op_set_wr = 1; op_clr_wr = 1; op_rts_bit = 1; tick(); op_set_wr = 0; op_clr_wr = 0;
    chk(rts_n == 1, "R4 set and clear together", rts_n, 1);
    cmd_wr = 1; cmd_code = 4'h8; op_clr_wr = 1; tick(); cmd_wr = 0; op_clr_wr = 0;
    chk(rts_n == 1, "R4 command set vs port clear", rts_n, 1);
    // R5 receiver control
    rx_rts_en = 1; rx_fifo_full = 1; tick();
    chk(rts_n == 1, "R5 fill keeps clear", rts_n, 1);
    rx_fifo_full = 0; tick();
    chk(rts_n == 0, "R5 drain sets without manual assert", rts_n, 0);
    rx_fifo_full = 1; tick();
    chk(rts_n == 1, "R5 fill clears", rts_n, 1);
    rx_rts_en = 0; rx_fifo_full = 0; tick();
    chk(rts_n == 1, "R5 disabled drain ignored", rts_n, 1);
    cmd_wr = 1; cmd_code = 4'h8; tick(); cmd_wr = 0;
    rx_fifo_full = 1; tick();
    chk(rts_n == 0, "R5 disabled fill ignored", rts_n, 0);
    rx_fifo_full = 0; tick();
    // R6 transmitter control
    tx_rts_en = 1; tx_buf_wr = 1; tx_buf_data = 8'h55; ad_bit = 0; tick(); tx_buf_wr = 0;
    tx_last_done = 1; tick(); tx_last_done = 0;
    chk(rts_n == 0, "R6 held character blocks clear", rts_n, 0);
    shift_ready = 1; tick(); shift_ready = 0;
    chk(frame_word == 9'h055 && frame_load == 1, "R8 frame out", frame_word, 9'h055);
    tx_last_done = 1; tick(); tx_last_done = 0;
    chk(rts_n == 1, "R6 end of transmission clears", rts_n, 1);
    tx_rts_en = 0; cmd_wr = 1; cmd_code = 4'h8; tick(); cmd_wr = 0;
    tx_last_done = 1; tick(); tx_last_done = 0;
    chk(rts_n == 0, "R6 disabled ignored", rts_n, 0);
    // R7 R8 holding stage
    tx_buf_wr = 1; tx_buf_data = 8'hA5; tick();
    chk(tx_rdy == 0, "R7 write fills", tx_rdy, 0);
    tx_buf_data = 8'h3C; tick(); tx_buf_wr = 0;
    chk(tx_rdy == 0, "R7 still full", tx_rdy, 0);
    ad_bit = 1; shift_ready = 1; tick(); shift_ready = 0;
    chk(frame_load == 1 && frame_word == 9'h1A5, "R7 R8 write while full discarded", frame_word, 9'h1A5);
    chk(tx_rdy == 1, "R8 ready on load", tx_rdy, 1);
    tick();
    chk(frame_load == 0 && frame_word == 0, "R8 one-cycle load", frame_word, 0);
    // R9 A/D capture
    ad_bit = 0; shift_ready = 1; tx_buf_wr = 1; tx_buf_data = 8'h11; tick(); tx_buf_wr = 0;
    tick();
    chk(frame_load == 1 && frame_word == 9'h011, "R9 flag at handover", frame_word, 9'h011);
    ad_bit = 1; tick();
    chk(frame_word == 0, "R9 change after ready", frame_word, 0);
    tx_buf_wr = 1; tx_buf_data = 8'h22; tick(); tx_buf_wr = 0;
    tick(); shift_ready = 0;
    chk(frame_load == 1 && frame_word == 9'h122, "R9 next character uses new flag", frame_word, 9'h122);
    repeat (3) tick();
    summary();
  end
endmodule